// File: doc/BRIEF.md
# Precision Time Counter with Staged Loads

This block keeps a time of day as 48 bits of seconds and 32 bits of nanoseconds, plus a separate 48-bit running nanosecond counter. Both advance on every 125 MHz clock by a 32-bit rate word that carries 28 fractional nanosecond bits. The nominal word 0x8000_0000 adds exactly 8 ns per clock. Software reaches the block through a small register bus with 16-bit words. New rate, time-of-day and counter values are written into staging registers. They reach the running state only when a frame-sync event occurs, so every change lands in a single clock.

A frame-sync event comes from the rising edge of an external pin, which is synchronised on the way in, or from software raising a control bit. Both sources are merged into at most one event per clock. The same event can also freeze the current time into a capture set and raise an interrupt flag. Software then copies the capture set into a read buffer, reads four words, and clears the flag with a closing strobe.

Top module: `ptp_nco_clock`

## Requirements
- R1: After reset the seconds, nanoseconds and counter outputs are zero, the applied rate is 0x8000_0000, and the control register (0x00), the load-flag register (0x01) and the status register (0x0D) read back zero.
- R2: Each clock adds the step word to the time: nanoseconds take its bits 31:28, and bits 27:0 go to a fraction that carries into the nanoseconds. The step word is the applied rate when the rate-select bit (bit 14 of register 0x0C) is 1, and 0x8000_0000 when it is 0.
- R3: When the sum of nanoseconds reaches 1,000,000,000 or more, 1,000,000,000 is subtracted and the seconds rise by one in that same clock. The nanosecond output therefore never reaches 1,000,000,000.
- R4: Software fires an event only when a write to control bit 0 raises it from 0 to 1. A write that leaves bit 0 at 1 fires nothing.
- R5: A rising edge of the sync pin fires an event that takes effect at the third clock edge after the pin is first sampled high. A pin edge and a software trigger in the same clock give one event.
- R6: The staged rate is written low half at 0x03 and high half at 0x04. It becomes the applied rate at an event only when load flag bit 6 (register 0x01) or permit bit 6 (register 0x02) is set. At any other time the applied rate stays unchanged.
- R7: When time-load flag bit 10 is set and the control value for the event has init bit 2 set, an event replaces seconds and nanoseconds with the staged words: 0x05 is ns[15:0], 0x06 is ns[31:16], and 0x07, 0x08 and 0x09 are sec[15:0], sec[31:16] and sec[47:32]. The fraction is zeroed. Without init the load is ignored and the flag stays set. An event with init clears flags 10, 9 and 7.
- R8: When counter-load flag bit 7 and init are set, an event sets the counter to the staged 44-bit value shifted left by 4. The value's bits are 0x0A for [15:0], 0x0B for [31:16] and 0x0C bits 11:0 for [43:32]. The counter fraction is zeroed.
- R9: An event whose control value has capture bit 1 set latches the seconds[31:0] and nanoseconds held before that edge. It also sets status bit 0, which drives the interrupt output.
- R10: Writing bit 10 to register 0x0E copies the capture set into the read buffer. Reads of 0x10 to 0x13 then return ns[15:0], ns[31:16], sec[15:0] and sec[31:16], one clock after the read strobe. Writing bit 11 to 0x0E clears status bit 0, and a capture in the same clock takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid one clock after bus_rd |
| fsync_pin | input | 1 | Asynchronous external frame-sync pin |
| tod_sec | output | 48 | Time-of-day seconds |
| tod_ns | output | 32 | Time-of-day nanoseconds |
| nco_ns | output | 48 | Running nanosecond counter |
| fsync_irq | output | 1 | Capture interrupt flag (status bit 0) |

## Verification
On every clock the assertions check that the nanoseconds stay below one second and that the seconds only hold or step by one between events. They also check that the applied rate stays frozen outside events, that a capture request raises the interrupt, and that a nominal step adds exactly 8 ns. The bench's scenarios are needed to show the rest. These are the staged-load gating by flag and init, the flags clearing themselves, the three-edge pin latency, and the rejection of a repeated high write. The same holds for the fractional carry and for the order and contents of the capture words returned over the bus.

// File: rtl/ptp_nco_pkg.sv
`timescale 1ns/1ps
package ptp_nco_pkg;
    localparam int BUS_AW    = 5;
    localparam int BUS_DW    = 16;
    localparam int SEC_W     = 48;
    localparam int NS_W      = 32;
    localparam int FRAC_W    = 28;
    localparam int FREQ_W    = 32;
    localparam int NCO_W     = 48;
    localparam int NCO_SHIFT = 4;
    localparam int NCO_VAL_W = NCO_W - NCO_SHIFT;
    localparam int NCO_TOP_W = NCO_VAL_W - 2 * BUS_DW;
    localparam int TC_WORDS  = 5;
    localparam int CAP_WORDS = 4;
    localparam int ACC_W     = NS_W + FRAC_W;
    localparam int NACC_W    = NCO_W + FRAC_W;

    localparam logic [NS_W-1:0]   NS_PER_SEC   = 32'd1_000_000_000;
    localparam logic [FREQ_W-1:0] FREQ_NOMINAL = 32'h8000_0000;

    localparam logic [BUS_AW-1:0] ADDR_CTRL    = 5'h00;
    localparam logic [BUS_AW-1:0] ADDR_LOAD    = 5'h01;
    localparam logic [BUS_AW-1:0] ADDR_PERMIT  = 5'h02;
    localparam logic [BUS_AW-1:0] ADDR_FREQ_LO = 5'h03;
    localparam logic [BUS_AW-1:0] ADDR_FREQ_HI = 5'h04;
    localparam logic [BUS_AW-1:0] ADDR_TC0     = 5'h05;
    localparam logic [BUS_AW-1:0] ADDR_NCO_LO  = 5'h0A;
    localparam logic [BUS_AW-1:0] ADDR_NCO_MID = 5'h0B;
    localparam logic [BUS_AW-1:0] ADDR_NCO_TOP = 5'h0C;
    localparam logic [BUS_AW-1:0] ADDR_STATUS  = 5'h0D;
    localparam logic [BUS_AW-1:0] ADDR_CAPCTL  = 5'h0E;
    localparam logic [BUS_AW-1:0] ADDR_CAPW0   = 5'h10;

    localparam int LD_TC      = 10;
    localparam int LD_SO      = 9;
    localparam int LD_NCO     = 7;
    localparam int LD_FREQ    = 6;
    localparam int PERMIT_BIT = 6;
    localparam int SEL_BIT    = 14;
    localparam int CAP_START  = 10;
    localparam int CAP_END    = 11;

    localparam logic [BUS_DW-1:0] LOAD_MASK  = 16'h06C0;
    localparam logic [BUS_DW-1:0] AUTO_CLEAR = 16'h0680;

    typedef struct packed {
        logic init;
        logic capture;
        logic trig;
    } ctrl_t;

    typedef struct packed {
        logic [FREQ_W-1:0]    freq;
        logic [SEC_W-1:0]     tc_sec;
        logic [NS_W-1:0]      tc_ns;
        logic [NCO_VAL_W-1:0] nco_val;
    } shadow_t;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [NS_W-1:0]   ns;
        logic [FRAC_W-1:0] frac;
    } tod_t;

    function automatic tod_t tod_advance(tod_t t, logic [FREQ_W-1:0] step);
        logic [ACC_W-1:0] acc;
        tod_t r;
        acc    = {t.ns, t.frac} + ACC_W'(step);
        r.frac = acc[FRAC_W-1:0];
        if (acc[ACC_W-1:FRAC_W] >= NS_PER_SEC) begin
            r.ns  = acc[ACC_W-1:FRAC_W] - NS_PER_SEC;
            r.sec = t.sec + SEC_W'(1);
        end else begin
            r.ns  = acc[ACC_W-1:FRAC_W];
            r.sec = t.sec;
        end
        return r;
    endfunction
endpackage

// File: rtl/ptp_fsync_detect.sv
`timescale 1ns/1ps
module ptp_fsync_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic sw_rise,
    output logic fire
);
    logic [SYNC_STAGES:0] sreg;
    logic pin_edge;

    always_ff @(posedge clk) begin
        if (rst) sreg <= '0;
        else     sreg <= {sreg[SYNC_STAGES-1:0], pin};
    end

    assign pin_edge = sreg[SYNC_STAGES-1] & ~sreg[SYNC_STAGES];
    assign fire     = pin_edge | sw_rise;
endmodule

// File: rtl/ptp_shadow_regs.sv
`timescale 1ns/1ps
module ptp_shadow_regs
    import ptp_nco_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BUS_AW-1:0] addr,
    input  logic [BUS_DW-1:0] wdata,
    input  logic              fire,
    output ctrl_t             ctrl_q,
    output ctrl_t             ctrl_eff,
    output logic              sw_rise,
    output logic [BUS_DW-1:0] load_q,
    output logic              permit_q,
    output logic              freq_sel_q,
    output shadow_t           shd
);
    logic ctrl_wr;
    logic [BUS_DW-1:0] freq_lo, freq_hi, nco_lo, nco_mid;
    logic [NCO_TOP_W-1:0] nco_top;
    logic [TC_WORDS-1:0][BUS_DW-1:0] tc_w;

    assign ctrl_wr  = wr_en && (addr == ADDR_CTRL);
    assign ctrl_eff = ctrl_wr ? ctrl_t'(wdata[2:0]) : ctrl_q;
    assign sw_rise  = ctrl_wr && wdata[0] && !ctrl_q.trig;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_t'(wdata[2:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '0;
        end else if (wr_en && addr == ADDR_LOAD) begin
            load_q <= wdata & LOAD_MASK;
        end else if (fire && ctrl_eff.init) begin
            load_q <= load_q & ~AUTO_CLEAR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            permit_q   <= 1'b0;
            freq_sel_q <= 1'b0;
            freq_lo    <= '0;
            freq_hi    <= '0;
            nco_lo     <= '0;
            nco_mid    <= '0;
            nco_top    <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_PERMIT:  permit_q <= wdata[PERMIT_BIT];
                ADDR_FREQ_LO: freq_lo  <= wdata;
                ADDR_FREQ_HI: freq_hi  <= wdata;
                ADDR_NCO_LO:  nco_lo   <= wdata;
                ADDR_NCO_MID: nco_mid  <= wdata;
                ADDR_NCO_TOP: begin
                    nco_top    <= wdata[NCO_TOP_W-1:0];
                    freq_sel_q <= wdata[SEL_BIT];
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < TC_WORDS; g++) begin : g_tc
        always_ff @(posedge clk) begin
            if (rst) begin
                tc_w[g] <= '0;
            end else if (wr_en && addr == ADDR_TC0 + BUS_AW'(g)) begin
                tc_w[g] <= wdata;
            end
        end
    end

    assign shd.freq    = {freq_hi, freq_lo};
    assign shd.tc_ns   = {tc_w[1], tc_w[0]};
    assign shd.tc_sec  = {tc_w[4], tc_w[3], tc_w[2]};
    assign shd.nco_val = {nco_top, nco_mid, nco_lo};
endmodule

// File: rtl/ptp_tod_core.sv
`timescale 1ns/1ps
module ptp_tod_core
    import ptp_nco_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              freq_sel,
    input  logic              apply_freq,
    input  logic              apply_tc,
    input  logic              apply_nco,
    input  shadow_t           shd,
    output logic [SEC_W-1:0]  sec,
    output logic [NS_W-1:0]   ns,
    output logic [NCO_W-1:0]  nco_ns,
    output logic [FREQ_W-1:0] active_freq,
    output logic [FREQ_W-1:0] step_freq
);
    tod_t tod_q, tod_next;
    logic [FRAC_W-1:0] nco_frac;
    logic [NACC_W-1:0] nco_sum;

    assign step_freq = freq_sel ? active_freq : FREQ_NOMINAL;
    assign tod_next  = tod_advance(tod_q, step_freq);
    assign nco_sum   = {nco_ns, nco_frac} + NACC_W'(step_freq);

    always_ff @(posedge clk) begin
        if (rst) begin
            tod_q <= '0;
        end else if (apply_tc) begin
            tod_q <= '{sec: shd.tc_sec, ns: shd.tc_ns, frac: '0};
        end else begin
            tod_q <= tod_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nco_ns   <= '0;
            nco_frac <= '0;
        end else if (apply_nco) begin
            nco_ns   <= {shd.nco_val, {NCO_SHIFT{1'b0}}};
            nco_frac <= '0;
        end else begin
            nco_ns   <= nco_sum[NACC_W-1:FRAC_W];
            nco_frac <= nco_sum[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             active_freq <= FREQ_NOMINAL;
        else if (apply_freq) active_freq <= shd.freq;
    end

    assign sec = tod_q.sec;
    assign ns  = tod_q.ns;
endmodule

// File: rtl/ptp_capture_unit.sv
`timescale 1ns/1ps
module ptp_capture_unit
    import ptp_nco_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            capture,
    input  logic [2*BUS_DW-1:0]             sec_lo,
    input  logic [NS_W-1:0]                 ns,
    input  logic                            start,
    input  logic                            finish,
    output logic                            irq,
    output logic [CAP_WORDS-1:0][BUS_DW-1:0] hold
);
    logic [CAP_WORDS-1:0][BUS_DW-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
            irq   <= 1'b0;
        end else if (capture) begin
            cap_q <= {sec_lo[31:16], sec_lo[15:0], ns[31:16], ns[15:0]};
            irq   <= 1'b1;
        end else if (finish) begin
            irq   <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        hold <= '0;
        else if (start) hold <= cap_q;
    end
endmodule

// File: rtl/ptp_nco_clock.sv
`timescale 1ns/1ps
module ptp_nco_clock
    import ptp_nco_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [4:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        fsync_pin,
    output logic [47:0] tod_sec,
    output logic [31:0] tod_ns,
    output logic [47:0] nco_ns,
    output logic        fsync_irq
);
    ctrl_t ctrl_q, ctrl_eff;
    shadow_t shd;
    logic sw_rise, fire, permit_q, freq_sel_q;
    logic [BUS_DW-1:0] load_q;
    logic [FREQ_W-1:0] active_freq, step_freq;
    logic apply_freq, apply_tc, apply_nco, capture_req, cap_start, cap_end;
    logic [CAP_WORDS-1:0][BUS_DW-1:0] hold;

    ptp_shadow_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .fire(fire), .ctrl_q(ctrl_q), .ctrl_eff(ctrl_eff), .sw_rise(sw_rise),
        .load_q(load_q), .permit_q(permit_q), .freq_sel_q(freq_sel_q), .shd(shd)
    );

    ptp_fsync_detect #(.SYNC_STAGES(SYNC_STAGES)) u_fsync (
        .clk(clk), .rst(rst), .pin(fsync_pin), .sw_rise(sw_rise), .fire(fire)
    );

    assign apply_freq  = fire && (load_q[LD_FREQ] || permit_q);
    assign apply_tc    = fire && ctrl_eff.init && load_q[LD_TC];
    assign apply_nco   = fire && ctrl_eff.init && load_q[LD_NCO];
    assign capture_req = fire && ctrl_eff.capture;
    assign cap_start   = bus_wr && bus_addr == ADDR_CAPCTL && bus_wdata[CAP_START];
    assign cap_end     = bus_wr && bus_addr == ADDR_CAPCTL && bus_wdata[CAP_END];

    ptp_tod_core u_core (
        .clk(clk), .rst(rst), .freq_sel(freq_sel_q), .apply_freq(apply_freq),
        .apply_tc(apply_tc), .apply_nco(apply_nco), .shd(shd),
        .sec(tod_sec), .ns(tod_ns), .nco_ns(nco_ns),
        .active_freq(active_freq), .step_freq(step_freq)
    );

    ptp_capture_unit u_cap (
        .clk(clk), .rst(rst), .capture(capture_req), .sec_lo(tod_sec[31:0]),
        .ns(tod_ns), .start(cap_start), .finish(cap_end), .irq(fsync_irq), .hold(hold)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                ADDR_CTRL:   bus_rdata <= {13'd0, ctrl_q};
                ADDR_LOAD:   bus_rdata <= load_q;
                ADDR_PERMIT: bus_rdata <= BUS_DW'({permit_q, {PERMIT_BIT{1'b0}}});
                ADDR_STATUS: bus_rdata <= {15'd0, fsync_irq};
                ADDR_CAPW0, ADDR_CAPW0 + 5'd1, ADDR_CAPW0 + 5'd2, ADDR_CAPW0 + 5'd3:
                             bus_rdata <= hold[bus_addr[1:0]];
                default:     bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/ptp_nco_clock_checker.sv
`timescale 1ns/1ps
module ptp_nco_clock_checker
    import ptp_nco_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fire,
    input logic              capture_req,
    input logic [SEC_W-1:0]  tod_sec,
    input logic [NS_W-1:0]   tod_ns,
    input logic              irq,
    input logic [FREQ_W-1:0] active_freq,
    input logic [FREQ_W-1:0] step_freq
);
    AST_NS_BELOW_SEC: assert property (@(posedge clk) disable iff (rst)
        tod_ns < NS_PER_SEC); // R3

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
        !fire |=> (tod_sec == $past(tod_sec) || tod_sec == $past(tod_sec) + 48'd1)); // R3

    AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(active_freq)); // R6

    AST_CAPTURE_IRQ: assert property (@(posedge clk) disable iff (rst)
        capture_req |=> irq); // R9

    AST_NOMINAL_STEP: assert property (@(posedge clk) disable iff (rst)
        (!fire && step_freq == FREQ_NOMINAL && tod_ns < NS_PER_SEC - 32'd16)
        |=> tod_ns == $past(tod_ns) + 32'd8); // R2
endmodule

bind ptp_nco_clock ptp_nco_clock_checker u_chk (
    .clk(clk), .rst(rst), .fire(fire), .capture_req(capture_req),
    .tod_sec(tod_sec), .tod_ns(tod_ns), .irq(fsync_irq),
    .active_freq(active_freq), .step_freq(step_freq)
);

// File: tb/ptp_nco_clock_bench.sv
`timescale 1ns/1ps
module ptp_nco_clock_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        fsync_pin = 1'b0;
    logic [15:0] bus_rdata;
    logic [47:0] tod_sec;
    logic [31:0] tod_ns;
    logic [47:0] nco_ns;
    logic        fsync_irq;

    int checks = 0;
    int failures = 0;

    ptp_nco_clock u_ptp_nco_clock (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fsync_pin(fsync_pin),
        .tod_sec(tod_sec), .tod_ns(tod_ns), .nco_ns(nco_ns), .fsync_irq(fsync_irq)
    );

    always #4 clk = ~clk;

    // behavioural reference state
    longint m_sec, m_ns, m_frac, m_nco, m_nfrac;
    logic [31:0] m_fact, m_fsh;
    logic [15:0] m_tc [5];
    logic [15:0] m_nw [3];
    logic [15:0] m_cap [4];
    logic [15:0] m_hold [4];
    logic [2:0]  m_ctrl;
    bit m_ldtc, m_ldso, m_ldnco, m_ldfreq, m_perm, m_sel, m_irq;
    bit s0, s1, s2;

    localparam longint BILLION = 64'd1000000000;
    localparam longint FMASK   = 64'h0FFFFFFF;
    localparam longint M48     = 64'hFFFFFFFFFFFF;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin : model
        bit wc, sw, pe, fire, capw;
        logic [2:0] ce;
        logic [31:0] ef;
        longint f;
        if (rst) begin
            m_sec = 0; m_ns = 0; m_frac = 0; m_nco = 0; m_nfrac = 0;
            m_fact = 32'h8000_0000; m_fsh = 0; m_ctrl = 0;
            m_ldtc = 0; m_ldso = 0; m_ldnco = 0; m_ldfreq = 0; m_perm = 0; m_sel = 0; m_irq = 0;
            s0 = 0; s1 = 0; s2 = 0;
            for (int i = 0; i < 5; i++) m_tc[i] = 0;
            for (int i = 0; i < 3; i++) m_nw[i] = 0;
            for (int i = 0; i < 4; i++) begin m_cap[i] = 0; m_hold[i] = 0; end
        end else begin
            wc   = bus_wr && bus_addr == 5'h00;
            ce   = wc ? bus_wdata[2:0] : m_ctrl;
            sw   = wc && bus_wdata[0] && !m_ctrl[0];
            pe   = s1 && !s2;
            fire = sw || pe;
            ef   = m_sel ? m_fact : 32'h8000_0000;
            capw = bus_wr && bus_addr == 5'h0E;
            if (capw && bus_wdata[10]) for (int i = 0; i < 4; i++) m_hold[i] = m_cap[i];
            if (fire && ce[1]) begin
                m_cap[0] = m_ns[15:0];  m_cap[1] = m_ns[31:16];
                m_cap[2] = m_sec[15:0]; m_cap[3] = m_sec[31:16];
                m_irq = 1;
            end else if (capw && bus_wdata[11]) m_irq = 0;
            if (fire && ce[2] && m_ldtc) begin
                m_ns  = {32'd0, m_tc[1], m_tc[0]};
                m_sec = {16'd0, m_tc[4], m_tc[3], m_tc[2]};
                m_frac = 0;
            end else begin
                f = m_frac + (longint'(ef) & FMASK);
                m_ns = m_ns + (longint'(ef) >> 28) + (f >> 28);
                m_frac = f & FMASK;
                if (m_ns >= BILLION) begin m_ns -= BILLION; m_sec = (m_sec + 1) & M48; end
            end
            if (fire && ce[2] && m_ldnco) begin
                m_nco = {16'd0, m_nw[2][11:0], m_nw[1], m_nw[0], 4'd0};
                m_nfrac = 0;
            end else begin
                f = m_nfrac + (longint'(ef) & FMASK);
                m_nco = (m_nco + (longint'(ef) >> 28) + (f >> 28)) & M48;
                m_nfrac = f & FMASK;
            end
            if (fire && (m_ldfreq || m_perm)) m_fact = m_fsh;
            if (bus_wr && bus_addr == 5'h01) begin
                m_ldtc = bus_wdata[10]; m_ldso = bus_wdata[9];
                m_ldnco = bus_wdata[7]; m_ldfreq = bus_wdata[6];
            end else if (fire && ce[2]) begin
                m_ldtc = 0; m_ldso = 0; m_ldnco = 0;
            end
            if (bus_wr) begin
                case (bus_addr)
                    5'h02: m_perm = bus_wdata[6];
                    5'h03: m_fsh[15:0] = bus_wdata;
                    5'h04: m_fsh[31:16] = bus_wdata;
                    5'h05, 5'h06, 5'h07, 5'h08, 5'h09: m_tc[bus_addr - 5'h05] = bus_wdata;
                    5'h0A: m_nw[0] = bus_wdata;
                    5'h0B: m_nw[1] = bus_wdata;
                    5'h0C: begin m_nw[2] = bus_wdata; m_sel = bus_wdata[14]; end
                    default: ;
                endcase
            end
            if (wc) m_ctrl = bus_wdata[2:0];
            s2 = s1; s1 = s0; s0 = fsync_pin;
        end
    end

    // per-clock comparison of all time outputs (R2 R3 R5 R6 R7 R8 R9)
    always @(negedge clk) begin
        if (!rst) begin
            chk(tod_sec == m_sec[47:0], "R3 R7 seconds", longint'(tod_sec), m_sec);
            chk(tod_ns == m_ns[31:0], "R2 R3 nanoseconds", longint'(tod_ns), m_ns);
            chk(nco_ns == m_nco[47:0], "R2 R8 counter", longint'(nco_ns), m_nco);
            chk(fsync_irq == m_irq, "R9 R10 irq", longint'(fsync_irq), longint'(m_irq));
        end
    end

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(bus_rdata == exp, tag, longint'(bus_rdata), longint'(exp));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        logic [31:0] a;
        logic [15:0] e [4];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(tod_sec == 0 && tod_ns == 0 && nco_ns == 0, "R1 reset time", longint'(tod_ns), 0);
        rd(5'h00, 16'h0000, "R1 ctrl");
        rd(5'h01, 16'h0000, "R1 load flags");
        rd(5'h0D, 16'h0000, "R1 status");
        idle(20);

        // R7 time load with init, then R3 rollover
        wr(5'h05, 16'hC99C); wr(5'h06, 16'h3B9A);
        wr(5'h07, 16'h0005); wr(5'h08, 16'h0000); wr(5'h09, 16'h0000);
        wr(5'h01, 16'h0400);
        wr(5'h00, 16'h0005);
        chk(tod_sec == 5 && tod_ns == 999_999_900, "R7 time loaded", longint'(tod_ns), 999_999_900);
        rd(5'h01, 16'h0000, "R7 flag self-cleared");
        wr(5'h00, 16'h0000);
        idle(20);
        chk(tod_sec == 6, "R3 seconds carried", longint'(tod_sec), 6);

        // R7 load without init is ignored
        wr(5'h07, 16'h0309);
        wr(5'h01, 16'h0400);
        wr(5'h00, 16'h0001);
        chk(tod_sec == 6, "R7 no init ignored", longint'(tod_sec), 6);
        rd(5'h01, 16'h0400, "R7 flag kept armed");
        wr(5'h00, 16'h0000);
        wr(5'h01, 16'h0000);

        // R4 software trigger only on 0->1
        wr(5'h00, 16'h0003);
        chk(fsync_irq == 1'b1, "R4 R9 capture on rise", longint'(fsync_irq), 1);
        wr(5'h0E, 16'h0800); wr(5'h0E, 16'h0000);
        chk(fsync_irq == 1'b0, "R10 end strobe clears", longint'(fsync_irq), 0);
        wr(5'h00, 16'h0003);
        chk(fsync_irq == 1'b0, "R4 repeated high write", longint'(fsync_irq), 0);
        wr(5'h00, 16'h0000);

        // R6 / R2 rate loading
        wr(5'h03, 16'h0000); wr(5'h04, 16'h9000);
        wr(5'h0C, 16'h4000);
        a = tod_ns; idle(1);
        chk(tod_ns == a + 8, "R6 staged rate not applied", longint'(tod_ns), longint'(a) + 8);
        wr(5'h01, 16'h0040);
        wr(5'h00, 16'h0001); wr(5'h00, 16'h0000); wr(5'h01, 16'h0000);
        a = tod_ns; idle(1);
        chk(tod_ns == a + 9, "R2 R6 loaded rate step", longint'(tod_ns), longint'(a) + 9);
        wr(5'h04, 16'hA000);
        wr(5'h00, 16'h0001); wr(5'h00, 16'h0000);
        a = tod_ns; idle(1);
        chk(tod_ns == a + 9, "R6 no flag keeps rate", longint'(tod_ns), longint'(a) + 9);
        wr(5'h02, 16'h0040);
        wr(5'h00, 16'h0001); wr(5'h00, 16'h0000);
        a = tod_ns; idle(1);
        chk(tod_ns == a + 10, "R6 permit applies rate", longint'(tod_ns), longint'(a) + 10);
        wr(5'h04, 16'h8800);
        wr(5'h00, 16'h0001); wr(5'h00, 16'h0000); wr(5'h02, 16'h0000);
        idle(12);

        // R8 counter load
        wr(5'h0A, 16'h1234); wr(5'h0B, 16'h0005); wr(5'h0C, 16'h4001);
        wr(5'h01, 16'h0080);
        wr(5'h00, 16'h0005);
        chk(nco_ns == 48'h0010_0051_2340, "R8 counter loaded", longint'(nco_ns), 64'h0010_0051_2340);
        wr(5'h00, 16'h0000);

        // R5 pin event with capture, R9 R10 readout
        wr(5'h00, 16'h0002);
        idle(3);
        @(negedge clk); fsync_pin = 1'b1;
        idle(2);
        chk(fsync_irq == 1'b0, "R5 not before third edge", longint'(fsync_irq), 0);
        idle(1);
        chk(fsync_irq == 1'b1, "R5 R9 pin event captured", longint'(fsync_irq), 1);
        idle(3); fsync_pin = 1'b0;
        wr(5'h0E, 16'h0400);
        for (int i = 0; i < 4; i++) e[i] = m_hold[i];
        rd(5'h10, e[0], "R10 word ns low");
        rd(5'h11, e[1], "R10 word ns high");
        rd(5'h12, e[2], "R10 word sec low");
        rd(5'h13, e[3], "R10 word sec high");
        rd(5'h0D, 16'h0001, "R9 status set");
        wr(5'h0E, 16'h0800); wr(5'h0E, 16'h0000);
        rd(5'h0D, 16'h0000, "R10 status cleared");
        idle(5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule